// File: doc/BRIEF.md
# Set-Associative Data Address Translation Buffer

This block converts the effective address of a data load or store into a real address. Pages are a fixed 4 kB, so the low twelve address bits pass through unchanged. The translations sit in a 64-set, 2-way set-associative store. The set index is the low six bits of the effective page number. When a lookup arrives with translation disabled, the effective address is returned unchanged as the real address. When translation is enabled, a matching entry supplies the real page number. Without a match, the access is reported as a miss, meaning it is not performed, and no interrupt is raised.

Software maintains the store through a command port that takes two 64-bit operands. The first operand carries the page number and the command code. The second operand carries a page-table-entry image. One command writes an entry, one clears every entry, and one clears a single entry. Alongside the lookup, the caller supplies a small set of data-cache way tags. Each TLB way compares its own real page number against every cache tag in parallel, and the TLB way that hits then selects the cache-hit vector. The real-page multiplexer and the cache tag compare are therefore not in series.

Top module: `dtlb`

## Requirements
- R1: After reset no response is valid and every entry is invalid, so a translated lookup misses.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and the response describes that request.
- R3: A lookup with `lk_xlate` low returns `rsp_hit`=1 and `rsp_ra` equal to `lk_ea`.
- R4: A translated hit returns `rsp_ra` = {8'b0, real page number, `lk_ea[11:0]`}.
- R5: A translated miss returns `rsp_hit`=0, `rsp_ra`=0 and `rsp_cache_hit`=0.
- R6: A command with `mt_rb[11:9]`=3'b001 writes a valid entry. Its page number is `mt_rb[63:12]`, its set is `mt_rb[17:12]`, and its real page number is `mt_pte[55:12]`. The other bits of `mt_pte` are ignored.
- R7: A command with `mt_rb[11:9]`≠3'b001 and either `mt_rb[10]` or `mt_rb[11]` set invalidates every entry.
- R8: A command with `mt_rb[11:9]`=3'b000 invalidates only an entry whose page number equals `mt_rb[63:12]`. Other entries, including the other way of the same set, remain valid.
- R9: A written entry is placed by the first rule that applies: (a) the way already holding that page number is overwritten; (b) otherwise the lowest-numbered invalid way is used; (c) otherwise the way named by a per-set round-robin pointer is replaced. The pointer starts at way 0 after reset and advances only on a replacement.
- R10: Bit c of `rsp_cache_hit` is set when the response hits and its real address bits 55:12 equal cache tag c, which is `lk_ctags[c*44 +: 44]` sampled with the request.
- R11: When a command and a lookup occur in the same cycle, the lookup sees the result of the command.
- R12: Two different pages that map to the same set can both be resident and hit. At most one way hits per lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_xlate | input | 1 | Translation enable for this lookup |
| lk_ea | input | 64 | Effective address |
| lk_ctags | input | 88 | Cache way tags, 44 bits each, way 0 lowest |
| mt_valid | input | 1 | Maintenance command strobe |
| mt_rb | input | 64 | Page number and command code |
| mt_pte | input | 64 | Page-table-entry image for a write |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation found (always set in real mode) |
| rsp_ra | output | 64 | Real address |
| rsp_cache_hit | output | 2 | Per cache-way tag match |

## Verification
A maintenance command and a lookup can land in the same cycle. The bench provokes this by raising both strobes on one edge. In one case it invalidates the very page being looked up, and it expects a miss. In the other case it writes a new page that is being looked up, and it expects a hit with the new real address. A bound property also checks that a flush issued alongside a translated lookup always yields a miss. Around these cases, the bench sweeps every set with two resident pages and walks the replacement order through eviction and overwrite.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int EA_W    = 64;
    localparam int PG_BITS = 12;
    localparam int EPN_W   = EA_W - PG_BITS;
    localparam int RPN_LSB = 12;
    localparam int RPN_MSB = 55;
    localparam int RPN_W   = RPN_MSB - RPN_LSB + 1;
    localparam int RA_PAD  = EA_W - PG_BITS - RPN_W;

    typedef enum logic [1:0] {
        MT_NOP,
        MT_FLUSH_ALL,
        MT_DROP_ONE,
        MT_WRITE
    } mt_op_e;

    typedef struct packed {
        logic            vld;
        logic            xl;
        logic [EA_W-1:0] ea;
    } lk_req_t;

    // Command decode: the write code wins over the flush bits it overlaps.
    function automatic mt_op_e mt_decode(input logic vld, input logic [EA_W-1:0] rb);
        mt_op_e op;
        if (!vld)
            op = MT_NOP;
        else if (rb[11:9] == 3'b001)
            op = MT_WRITE;
        else if (rb[10] || rb[11])
            op = MT_FLUSH_ALL;
        else
            op = MT_DROP_ONE;
        return op;
    endfunction

    function automatic logic [RPN_W-1:0] pte_rpn(input logic [EA_W-1:0] pte);
        return pte[RPN_MSB:RPN_LSB];
    endfunction

endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
    import dtlb_pkg::*;
#(
    parameter int WAYS = 2,
    parameter int SETS = 64,
    localparam int SET_BITS = $clog2(SETS),
    localparam int TAG_W    = EPN_W - SET_BITS,
    localparam int WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [SET_BITS-1:0]              rd_set,
    output logic [WAYS-1:0]                  rd_v,
    output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [WAYS-1:0][RPN_W-1:0]       rd_rpn,
    input  mt_op_e                           mt_op,
    input  logic [EPN_W-1:0]                 mt_epn,
    input  logic [RPN_W-1:0]                 mt_rpn
);

    logic [WAYS-1:0]             vbits [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tags  [SETS];
    logic [WAYS-1:0][RPN_W-1:0]  rpns  [SETS];
    logic [WAY_BITS-1:0]         rrptr [SETS];

    logic [SET_BITS-1:0] mset;
    logic [TAG_W-1:0]    mtag;
    logic [WAYS-1:0]     mhit;
    logic [WAY_BITS-1:0] victim;
    logic                use_rr;

    assign mset = mt_epn[SET_BITS-1:0];
    assign mtag = mt_epn[EPN_W-1:SET_BITS];

    always_comb begin
        for (int w = 0; w < WAYS; w++)
            mhit[w] = vbits[mset][w] && (tags[mset][w] == mtag);
    end

    // Placement priority: same page, then lowest free way, then pointer.
    always_comb begin
        victim = rrptr[mset];
        use_rr = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vbits[mset][w]) begin
                victim = WAY_BITS'(w);
                use_rr = 1'b0;
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (mhit[w]) begin
                victim = WAY_BITS'(w);
                use_rr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vbits[s] <= '0;
                rrptr[s] <= '0;
            end
        end else begin
            case (mt_op)
                MT_FLUSH_ALL: begin
                    for (int s = 0; s < SETS; s++)
                        vbits[s] <= '0;
                end
                MT_DROP_ONE: vbits[mset] <= vbits[mset] & ~mhit;
                MT_WRITE: begin
                    vbits[mset][victim] <= 1'b1;
                    if (use_rr)
                        rrptr[mset] <= rrptr[mset] + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (mt_op == MT_WRITE) begin
            tags[mset][victim] <= mtag;
            rpns[mset][victim] <= mt_rpn;
        end
    end

    assign rd_v   = vbits[rd_set];
    assign rd_tag = tags[rd_set];
    assign rd_rpn = rpns[rd_set];

endmodule

// File: rtl/dtlb_way_cmp.sv
module dtlb_way_cmp
    import dtlb_pkg::*;
#(
    parameter int CWAYS = 2,
    parameter int TAG_W = 46
) (
    input  logic                        ent_v,
    input  logic [TAG_W-1:0]            ent_tag,
    input  logic [RPN_W-1:0]            ent_rpn,
    input  logic [TAG_W-1:0]            ea_tag,
    input  logic [CWAYS-1:0][RPN_W-1:0] ctags,
    output logic                        hit,
    output logic [CWAYS-1:0]            cmatch
);

    assign hit = ent_v && (ent_tag == ea_tag);

    // One comparator per cache way, fed straight from this way's entry.
    for (genvar c = 0; c < CWAYS; c++) begin : g_ctag
        assign cmatch[c] = (ent_rpn == ctags[c]);
    end

endmodule

// File: rtl/dtlb.sv
module dtlb
    import dtlb_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int SETS  = 64,
    parameter int CWAYS = 2,
    localparam int SET_BITS = $clog2(SETS),
    localparam int TAG_W    = EPN_W - SET_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lk_valid,
    input  logic                   lk_xlate,
    input  logic [EA_W-1:0]        lk_ea,
    input  logic [CWAYS*RPN_W-1:0] lk_ctags,
    input  logic                   mt_valid,
    input  logic [EA_W-1:0]        mt_rb,
    input  logic [EA_W-1:0]        mt_pte,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [EA_W-1:0]        rsp_ra,
    output logic [CWAYS-1:0]       rsp_cache_hit
);

    lk_req_t                     req_q;
    logic [CWAYS-1:0][RPN_W-1:0] ctag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q.vld <= 1'b0;
        end else begin
            req_q.vld <= lk_valid;
        end
        if (lk_valid) begin
            req_q.xl <= lk_xlate;
            req_q.ea <= lk_ea;
            ctag_q   <= lk_ctags;
        end
    end

    mt_op_e mt_op;
    assign mt_op = mt_decode(mt_valid, mt_rb);

    logic [WAYS-1:0]            rd_v;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0][RPN_W-1:0] rd_rpn;

    // Commands land at the edge closing their cycle; the registered lookup
    // reads the array afterwards, which orders command before lookup.
    dtlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
        .clk    (clk),
        .rst    (rst),
        .rd_set (req_q.ea[PG_BITS +: SET_BITS]),
        .rd_v   (rd_v),
        .rd_tag (rd_tag),
        .rd_rpn (rd_rpn),
        .mt_op  (mt_op),
        .mt_epn (mt_rb[EA_W-1:PG_BITS]),
        .mt_rpn (pte_rpn(mt_pte))
    );

    logic [WAYS-1:0]            hit_vec;
    logic [WAYS-1:0][CWAYS-1:0] cm;
    logic [TAG_W-1:0]           ea_tag;

    assign ea_tag = req_q.ea[EA_W-1:PG_BITS+SET_BITS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        dtlb_way_cmp #(.CWAYS(CWAYS), .TAG_W(TAG_W)) u_cmp (
            .ent_v   (rd_v[w]),
            .ent_tag (rd_tag[w]),
            .ent_rpn (rd_rpn[w]),
            .ea_tag  (ea_tag),
            .ctags   (ctag_q),
            .hit     (hit_vec[w]),
            .cmatch  (cm[w])
        );
    end

    logic [CWAYS-1:0] rm_cm;
    for (genvar c = 0; c < CWAYS; c++) begin : g_real
        assign rm_cm[c] = (req_q.ea[PG_BITS +: RPN_W] == ctag_q[c]);
    end

    logic [RPN_W-1:0] sel_rpn;
    logic [CWAYS-1:0] tr_cm;

    always_comb begin
        sel_rpn = '0;
        tr_cm   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                sel_rpn = sel_rpn | rd_rpn[w];
                tr_cm   = tr_cm | cm[w];
            end
        end
    end

    always_comb begin
        rsp_valid     = req_q.vld;
        rsp_hit       = 1'b0;
        rsp_ra        = '0;
        rsp_cache_hit = '0;
        if (req_q.vld) begin
            if (!req_q.xl) begin
                rsp_hit       = 1'b1;
                rsp_ra        = req_q.ea;
                rsp_cache_hit = rm_cm;
            end else if (|hit_vec) begin
                rsp_hit       = 1'b1;
                rsp_ra        = {{RA_PAD{1'b0}}, sel_rpn, req_q.ea[PG_BITS-1:0]};
                rsp_cache_hit = tr_cm;
            end
        end
    end

endmodule

// File: rtl/dtlb_chk.sv
module dtlb_chk
    import dtlb_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int CWAYS = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_xlate,
    input logic [EA_W-1:0]  lk_ea,
    input logic             mt_valid,
    input logic [EA_W-1:0]  mt_rb,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [EA_W-1:0]  rsp_ra,
    input logic [CWAYS-1:0] rsp_cache_hit,
    input logic [WAYS-1:0]  hit_vec
);

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid); // R2

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid); // R2

    AST_REAL_PASS: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_xlate) |=> (rsp_hit && rsp_ra == $past(lk_ea))); // R3

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_xlate) |=> (!rsp_hit || rsp_ra[PG_BITS-1:0] == $past(lk_ea[PG_BITS-1:0]))); // R4

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_ra == '0 && rsp_cache_hit == '0)); // R5

    AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (rst)
        (mt_valid && mt_rb[11:9] != 3'b001 && (mt_rb[10] || mt_rb[11]) && lk_valid && lk_xlate)
        |=> !rsp_hit); // R11

    AST_CACHE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cache_hit != '0) |-> rsp_hit); // R10

    AST_WAY_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R12

endmodule

bind dtlb dtlb_chk #(.WAYS(WAYS), .CWAYS(CWAYS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_xlate      (lk_xlate),
    .lk_ea         (lk_ea),
    .mt_valid      (mt_valid),
    .mt_rb         (mt_rb),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_ra        (rsp_ra),
    .rsp_cache_hit (rsp_cache_hit),
    .hit_vec       (hit_vec)
);

// File: tb/tb_dtlb.sv
module tb_dtlb;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic        lk_xlate = 1'b0;
    logic [63:0] lk_ea = '0;
    logic [87:0] lk_ctags = '0;
    logic        mt_valid = 1'b0;
    logic [63:0] mt_rb = '0;
    logic [63:0] mt_pte = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_ra;
    logic [1:0]  rsp_cache_hit;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    dtlb dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_xlate(lk_xlate), .lk_ea(lk_ea),
        .lk_ctags(lk_ctags), .mt_valid(mt_valid), .mt_rb(mt_rb), .mt_pte(mt_pte),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra), .rsp_cache_hit(rsp_cache_hit)
    );

    localparam logic [45:0] TA = 46'h0001_A2B3_C4D5;
    localparam logic [45:0] TB = 46'h0000_0000_0002;
    localparam logic [45:0] TC = 46'h3FFF_FFFF_FFFF;
    localparam logic [45:0] TD = 46'h0000_0000_0000;
    localparam logic [45:0] TE = 46'h1555_5555_5555;
    localparam logic [45:0] TZ = 46'h0ABC_0000_0777;

    function automatic logic [63:0] ea_of(logic [45:0] t, int s, logic [11:0] off);
        return {t, 6'(s), off};
    endfunction

    function automatic logic [43:0] rpn_of(int k);
        return 44'hC00_0000_0000 + 44'(k) * 44'h1_0101 + 44'd7;
    endfunction

    function automatic logic [63:0] pte_of(logic [43:0] rpn);
        return {8'hEE, rpn, 12'h5A5};
    endfunction

    function automatic logic [63:0] ra_of(logic [43:0] rpn, logic [11:0] off);
        return {8'h00, rpn, off};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mt_cmd(logic [63:0] rb, logic [63:0] pte);
        @(negedge clk);
        mt_valid = 1'b1; mt_rb = rb; mt_pte = pte;
        @(negedge clk);
        mt_valid = 1'b0;
    endtask

    task automatic look(logic [63:0] ea, logic xl, logic [43:0] c0, logic [43:0] c1);
        @(negedge clk);
        lk_valid = 1'b1; lk_xlate = xl; lk_ea = ea; lk_ctags = {c1, c0};
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic both(logic [63:0] rb, logic [63:0] pte, logic [63:0] ea);
        @(negedge clk);
        mt_valid = 1'b1; mt_rb = rb; mt_pte = pte;
        lk_valid = 1'b1; lk_xlate = 1'b1; lk_ea = ea; lk_ctags = '0;
        @(negedge clk);
        mt_valid = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, logic [63:0] ea, logic [43:0] rpn);
        look(ea, 1'b1, 44'h0, 44'h0);
        check(req, {63'h0, rsp_hit}, 64'h1);
        check(req, rsp_ra, ra_of(rpn, ea[11:0]));
    endtask

    task automatic expect_miss(string req, logic [63:0] ea);
        look(ea, 1'b1, ea[55:12], ea[55:12]);
        check(req, {63'h0, rsp_hit}, 64'h0);
        check(req, rsp_ra, 64'h0);
        check(req, {62'h0, rsp_cache_hit}, 64'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] ea;
        repeat (4) @(negedge clk);
        check("R1 reset valid", {63'h0, rsp_valid}, 64'h0);
        rst = 1'b0;

        // R1 R5 R2: empty store misses, response one cycle later
        look(ea_of(TA, 3, 12'h123), 1'b1, 44'h0, 44'h0);
        check("R2 rsp_valid", {63'h0, rsp_valid}, 64'h1);
        check("R1 empty miss", {63'h0, rsp_hit}, 64'h0);
        check("R5 miss ra", rsp_ra, 64'h0);
        @(negedge clk);
        check("R2 rsp idle", {63'h0, rsp_valid}, 64'h0);

        // R3 R10: real mode pass-through and cache match
        for (int i = 0; i < 8; i++) begin
            ea = {8'(i * 37 + 1), 44'(i) * 44'h123_4567_89AB, 12'(i * 291)};
            if (i % 2 == 0) begin
                look(ea, 1'b0, ea[55:12], ea[55:12] ^ 44'h1);
                check("R10 real cache vec", {62'h0, rsp_cache_hit}, 64'h1);
            end else begin
                look(ea, 1'b0, ea[55:12] ^ 44'h2, ea[55:12]);
                check("R10 real cache vec", {62'h0, rsp_cache_hit}, 64'h2);
            end
            check("R3 real hit", {63'h0, rsp_hit}, 64'h1);
            check("R3 real ra", rsp_ra, ea);
        end

        // R6 R4: fill way 0 of every set, then way 1
        for (int s = 0; s < 64; s++)
            mt_cmd({TA, 6'(s), 12'h200}, pte_of(rpn_of(s)));
        for (int s = 0; s < 64; s++)
            expect_hit("R4 R6 sweep A", ea_of(TA, s, 12'(s * 61)), rpn_of(s));
        for (int s = 0; s < 64; s++)
            mt_cmd({TB, 6'(s), 12'h200}, pte_of(rpn_of(100 + s)));
        for (int s = 0; s < 64; s++) begin
            expect_hit("R12 both ways A", ea_of(TA, s, 12'hFFF), rpn_of(s));
            expect_hit("R12 both ways B", ea_of(TB, s, 12'h000), rpn_of(100 + s));
        end

        // R9: replacement order in set 5
        mt_cmd({TC, 6'd5, 12'h200}, pte_of(rpn_of(200)));
        expect_miss("R9 rr evicts way0", ea_of(TA, 5, 12'h010));
        expect_hit("R9 way1 kept", ea_of(TB, 5, 12'h010), rpn_of(105));
        expect_hit("R9 new entry", ea_of(TC, 5, 12'h010), rpn_of(200));
        mt_cmd({TD, 6'd5, 12'h200}, pte_of(rpn_of(201)));
        expect_miss("R9 rr evicts way1", ea_of(TB, 5, 12'h020));
        expect_hit("R9 way0 kept", ea_of(TC, 5, 12'h020), rpn_of(200));
        expect_hit("R9 second new", ea_of(TD, 5, 12'h020), rpn_of(201));
        mt_cmd({TC, 6'd5, 12'h200}, pte_of(rpn_of(202)));
        expect_hit("R9 overwrite same page", ea_of(TC, 5, 12'h030), rpn_of(202));
        expect_hit("R9 overwrite spares other", ea_of(TD, 5, 12'h030), rpn_of(201));
        expect_hit("R9 other set intact", ea_of(TA, 6, 12'h030), rpn_of(6));

        // R8: single invalidation
        mt_cmd({TC, 6'd5, 12'h000}, 64'h0);
        expect_miss("R8 dropped page", ea_of(TC, 5, 12'h040));
        expect_hit("R8 neighbour way", ea_of(TD, 5, 12'h040), rpn_of(201));
        mt_cmd({TZ, 6'd6, 12'h000}, 64'h0);
        expect_hit("R8 absent page A", ea_of(TA, 6, 12'h050), rpn_of(6));
        expect_hit("R8 absent page B", ea_of(TB, 6, 12'h050), rpn_of(106));

        // R10: translated cache vector
        look(ea_of(TD, 5, 12'h060), 1'b1, rpn_of(201), rpn_of(1));
        check("R10 way0 tag", {62'h0, rsp_cache_hit}, 64'h1);
        look(ea_of(TD, 5, 12'h060), 1'b1, rpn_of(1), rpn_of(201));
        check("R10 way1 tag", {62'h0, rsp_cache_hit}, 64'h2);
        look(ea_of(TD, 5, 12'h060), 1'b1, rpn_of(201), rpn_of(201));
        check("R10 both tags", {62'h0, rsp_cache_hit}, 64'h3);
        look(ea_of(TC, 5, 12'h060), 1'b1, rpn_of(202), rpn_of(202));
        check("R10 miss no cache hit", {62'h0, rsp_cache_hit}, 64'h0);

        // R11: command and lookup in one cycle
        both({TD, 6'd5, 12'h000}, 64'h0, ea_of(TD, 5, 12'h070));
        check("R11 drop then look", {63'h0, rsp_hit}, 64'h0);
        both({TE, 6'd9, 12'h200}, pte_of(rpn_of(300)), ea_of(TE, 9, 12'h070));
        check("R11 write then look hit", {63'h0, rsp_hit}, 64'h1);
        check("R11 write then look ra", rsp_ra, ra_of(rpn_of(300), 12'h070));

        // R7: flush all, two flush bit positions and an overlapping code
        mt_cmd({TZ, 6'd0, 12'h400}, 64'h0);
        for (int s = 0; s < 64; s++) begin
            look(ea_of(TB, s, 12'h0), 1'b1, 44'h0, 44'h0);
            check("R7 flush bit10", {63'h0, rsp_hit}, 64'h0);
        end
        mt_cmd({TA, 6'd2, 12'h200}, pte_of(rpn_of(400)));
        expect_hit("R6 reload", ea_of(TA, 2, 12'h080), rpn_of(400));
        mt_cmd({TZ, 6'd0, 12'h800}, 64'h0);
        expect_miss("R7 flush bit11", ea_of(TA, 2, 12'h080));
        mt_cmd({TA, 6'd2, 12'h200}, pte_of(rpn_of(401)));
        mt_cmd({TA, 6'd2, 12'h600}, pte_of(rpn_of(402)));
        expect_miss("R7 code 011 flushes", ea_of(TA, 2, 12'h090));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule